// File: doc/BRIEF.md
# Single-wire bus search step sequencer

This block carries out one decision step of the address search on a single-wire bus. A one-cycle start pulse launches the step, together with the branch direction the search loop would like to take. The sequencer then asks an underlying bit engine for two read slots: first the address bit, then its complement. From the pair it decides which way the search goes, sends that direction back to the bus as a write slot, and reports a three-bit result code with a one-cycle done pulse.

Slot waveform timing is left to the bit engine. The sequencer only exchanges a one-cycle request, a read/write select, a write value, a one-cycle completion strobe and the sampled read value with it. A per-phase cycle watchdog, whose limit comes in on a port, aborts the step if the engine stops answering. The outer 64-step loop that walks a whole address belongs to the caller.

Top module: `owsrch_step`

## Requirements
- R1: A step issues its slot requests in a fixed order: a read slot for the address bit, then a read slot for the complement bit, then (when needed) a write slot. Each `bit_req` lasts one cycle, and a request is issued only after the previous slot's `bit_done` has arrived. `bit_rd`=1 marks a read slot.
- R2: When both read values are 1, no device answered. The step finishes with code 3'b011 after only two slot requests, with no write slot.
- R3: When both read values are 0, the branch follows `want_dir` as sampled at start. The code is 3'b100 for direction 1 and 3'b000 for direction 0.
- R4: When exactly one read value is 1, the branch follows the address bit. The code is 3'b101 when the address bit is 1 and 3'b010 when it is 0.
- R5: Code layout: bit 0 is the address bit read, bit 1 is the complement bit read, and bit 2 is the direction taken.
- R6: The write slot carries the chosen direction on `bit_wval` in its request cycle. The step finishes only after that slot's `bit_done`.
- R7: `step_go` is a one-cycle pulse. While `busy` is high, further pulses are ignored: no extra slot, no extra done, and no change in timing.
- R8: `step_done` is high for exactly one cycle, in the cycle after the final slot completion (or after the abort). `step_code` and `step_err` are valid in that cycle.
- R9: If `bit_done` has not arrived by the wait cycle numbered `tmo_limit` (counting from 0 in the cycle after the request), the step aborts in that phase. It then returns code 3'b011 with `step_err`=1. A completion that arrives in that same cycle is still accepted.
- R10: With an engine latency of L cycles from request to completion, done arrives 3L+4 clock edges after the start edge (counting that edge as 1) for a full step, and 2L+3 edges for a step that skips the write.
- R11: During and after reset the sequencer is idle: `busy`, `bit_req`, `step_done` and `step_err` are all 0. Reset is asserted asynchronously and released synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_go | input | 1 | One-cycle start pulse |
| want_dir | input | 1 | Requested branch for the both-zero case |
| tmo_limit | input | TMO_W | Watchdog limit per slot phase, in wait cycles |
| busy | output | 1 | Step in progress |
| step_done | output | 1 | One-cycle completion pulse |
| step_code | output | 3 | {direction, complement bit, address bit} |
| step_err | output | 1 | Step aborted by the watchdog |
| bit_req | output | 1 | One-cycle slot request to the bit engine |
| bit_rd | output | 1 | 1 = read slot, 0 = write slot |
| bit_wval | output | 1 | Bit to send in a write slot |
| bit_done | input | 1 | Slot completion strobe from the bit engine |
| bit_rval | input | 1 | Bit sampled in a read slot, valid with bit_done |

## Verification
A state register that skipped or repeated a phase would show within one step as a wrong number of slot requests, seen by the bench's bit-engine model, and as a done pulse at the wrong edge count. The edge count is checked exactly for each engine latency. A read value captured into the wrong field would swap code bits 0 and 1, which the vector table exposes for the asymmetric pairs. A watchdog that is off by one is caught by the two latencies on either side of the limit, where the accepted and aborted outcomes differ at the very next done pulse.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ID_ISS = 3'd1,
    PH_ID_WT  = 3'd2,
    PH_CP_ISS = 3'd3,
    PH_CP_WT  = 3'd4,
    PH_WR_ISS = 3'd5,
    PH_WR_WT  = 3'd6
  } phase_e;

  localparam logic [2:0] CODE_NONE = 3'b011;

  function automatic logic [2:0] pack_code(input logic dir, input logic cmp, input logic id);
    return {dir, cmp, id};
  endfunction

endpackage

// File: rtl/owsrch_rstsync.sv
module owsrch_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sh_q[STAGES-1];
endmodule

// File: rtl/owsrch_pick.sv
module owsrch_pick
  import owsrch_pkg::*;
(
  input  logic       id_bit,
  input  logic       cmp_bit,
  input  logic       want_dir,
  output logic       no_resp,
  output logic       dir_take,
  output logic [2:0] code
);
  always_comb begin
    no_resp = id_bit & cmp_bit;
    if (no_resp)              dir_take = 1'b0;
    else if (id_bit ^ cmp_bit) dir_take = id_bit;
    else                      dir_take = want_dir;
    code = pack_code(dir_take, cmp_bit, id_bit);
  end

  always_comb begin
    a_r4_single_follows_id: assert ((id_bit == cmp_bit) || (dir_take == id_bit));
  end
endmodule

// File: rtl/owsrch_wdog.sv
module owsrch_wdog #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_lim;

  assign at_lim = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (run && !at_lim) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign expired = run & at_lim;

  a_r9_starts_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/owsrch_step.sv
module owsrch_step
  import owsrch_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_go,
  input  logic             want_dir,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             step_done,
  output logic [2:0]       step_code,
  output logic             step_err,
  output logic             bit_req,
  output logic             bit_rd,
  output logic             bit_wval,
  input  logic             bit_done,
  input  logic             bit_rval
);
  localparam int CNT_W = TMO_W;

  logic   rst_ns;
  phase_e ph_q, ph_d;
  logic   id_q, cp_q, want_q;
  logic   id_en, cp_en, want_en;
  logic   done_q, done_d, err_q, err_d;
  logic [2:0] code_q, code_d;
  logic   waiting, issuing, expired;
  logic   cmp_in, no_resp, dir_take;
  logic [2:0] pick_code;

  owsrch_rstsync #(.STAGES(2)) u_rs (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  assign waiting = (ph_q == PH_ID_WT) || (ph_q == PH_CP_WT) || (ph_q == PH_WR_WT);
  assign issuing = (ph_q == PH_ID_ISS) || (ph_q == PH_CP_ISS) || (ph_q == PH_WR_ISS);

  owsrch_wdog #(.CNT_W(CNT_W)) u_wd (
    .clk(clk), .rst_ns(rst_ns), .clr(!waiting), .run(waiting),
    .limit(tmo_limit), .expired(expired)
  );

  assign cmp_in = (ph_q == PH_CP_WT) ? bit_rval : cp_q;

  owsrch_pick u_pick (
    .id_bit(id_q), .cmp_bit(cmp_in), .want_dir(want_q),
    .no_resp(no_resp), .dir_take(dir_take), .code(pick_code)
  );

  always_comb begin
    ph_d    = ph_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    code_d  = code_q;
    id_en   = 1'b0;
    cp_en   = 1'b0;
    want_en = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (step_go) begin
        ph_d    = PH_ID_ISS;
        want_en = 1'b1;
      end
      PH_ID_ISS: ph_d = PH_ID_WT;
      PH_ID_WT: begin
        if (bit_done) begin
          id_en = 1'b1;
          ph_d  = PH_CP_ISS;
        end else if (expired) begin
          ph_d = PH_IDLE; done_d = 1'b1; err_d = 1'b1; code_d = CODE_NONE;
        end
      end
      PH_CP_ISS: ph_d = PH_CP_WT;
      PH_CP_WT: begin
        if (bit_done) begin
          cp_en = 1'b1;
          if (no_resp) begin
            ph_d = PH_IDLE; done_d = 1'b1; code_d = CODE_NONE;
          end else begin
            ph_d = PH_WR_ISS;
          end
        end else if (expired) begin
          ph_d = PH_IDLE; done_d = 1'b1; err_d = 1'b1; code_d = CODE_NONE;
        end
      end
      PH_WR_ISS: ph_d = PH_WR_WT;
      PH_WR_WT: begin
        if (bit_done) begin
          ph_d = PH_IDLE; done_d = 1'b1; code_d = pick_code;
        end else if (expired) begin
          ph_d = PH_IDLE; done_d = 1'b1; err_d = 1'b1; code_d = CODE_NONE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= CODE_NONE;
      id_q   <= 1'b0;
      cp_q   <= 1'b0;
      want_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (done_d)  code_q <= code_d;
      if (id_en)   id_q   <= bit_rval;
      if (cp_en)   cp_q   <= bit_rval;
      if (want_en) want_q <= want_dir;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign bit_req   = issuing;
  assign bit_rd    = (ph_q == PH_ID_ISS) || (ph_q == PH_CP_ISS);
  assign bit_wval  = (ph_q == PH_WR_ISS) & dir_take;
  assign step_done = done_q;
  assign step_code = code_q;
  assign step_err  = err_q;

  a_r1_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_ns)
    bit_req |=> !bit_req);
  a_r1_no_req_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> !bit_req);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    step_done |=> !step_done);
  a_r9_err_code: assert property (@(posedge clk) disable iff (!rst_ns)
    step_err |-> (step_done && step_code == CODE_NONE));
  a_r3_dir_clears_cmp: assert property (@(posedge clk) disable iff (!rst_ns)
    (step_done && step_code[2]) |-> !step_code[1]);
  a_r4_code_follows_id: assert property (@(posedge clk) disable iff (!rst_ns)
    (step_done && (step_code[1] ^ step_code[0])) |-> (step_code[2] == step_code[0]));
  a_r7_go_ignored_busy: assert property (@(posedge clk) disable iff (!rst_ns)
    (step_go && busy) |=> (busy || step_done));
  a_r2_none_no_write: assert property (@(posedge clk) disable iff (!rst_ns)
    (step_done && !step_err && step_code == CODE_NONE) |-> !$past(bit_req));
endmodule

// File: tb/owsrch_step_tb.sv
module owsrch_step_tb;
  logic clk, rst_n, step_go, want_dir;
  logic [7:0] tmo_limit;
  logic busy, step_done, step_err, bit_req, bit_rd, bit_wval, bit_done, bit_rval;
  logic [2:0] step_code;

  int total = 0;
  int bad = 0;

  // bit engine model
  logic       eng_clr;
  logic       id_v, cmp_v;
  logic [4:0] lat_v;
  int         mute_v;
  logic [4:0] cnt_e;
  int         reqs;
  logic       rval_q, wr_seen, wr_val;

  owsrch_step #(.TMO_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_go(step_go), .want_dir(want_dir),
    .tmo_limit(tmo_limit), .busy(busy), .step_done(step_done),
    .step_code(step_code), .step_err(step_err), .bit_req(bit_req),
    .bit_rd(bit_rd), .bit_wval(bit_wval), .bit_done(bit_done), .bit_rval(bit_rval)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (eng_clr) begin
      cnt_e <= '0; reqs <= 0; rval_q <= 1'b0; wr_seen <= 1'b0; wr_val <= 1'b0;
    end else begin
      if (cnt_e != 0) cnt_e <= cnt_e - 1'b1;
      if (bit_req) begin
        reqs <= reqs + 1;
        if (mute_v != reqs + 1) cnt_e <= lat_v;
        if (bit_rd) rval_q <= (reqs == 0) ? id_v : cmp_v;
        else begin wr_seen <= 1'b1; wr_val <= bit_wval; end
      end
    end
  end
  assign bit_done = (cnt_e == 5'd1);
  assign bit_rval = rval_q;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // runs one step; returns edges to done, code, err
  task automatic run_step(input logic id, input logic cmp, input logic dir,
                          input int lat, input int mute, input int extra_go,
                          output int n, output logic [2:0] code, output logic err);
    @(negedge clk);
    id_v = id; cmp_v = cmp; lat_v = lat[4:0]; mute_v = mute; eng_clr = 1'b1;
    @(negedge clk);
    eng_clr = 1'b0; step_go = 1'b1; want_dir = dir;
    n = 0; code = 3'b111; err = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      step_go = (n == extra_go);
      if (step_done) begin
        code = step_code; err = step_err;
        break;
      end
    end
    step_go = 1'b0;
    @(negedge clk);
    chk(!step_done, "R8 done one cycle", step_done, 0);
  endtask

  // {id, cmp, dir, lat[3:0], code[2:0]}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 4'd1, 3'b000},
    {1'b0, 1'b0, 1'b1, 4'd2, 3'b100},
    {1'b0, 1'b1, 1'b0, 4'd3, 3'b010},
    {1'b0, 1'b1, 1'b1, 4'd1, 3'b010},
    {1'b1, 1'b0, 1'b0, 4'd2, 3'b101},
    {1'b1, 1'b0, 1'b1, 4'd4, 3'b101},
    {1'b1, 1'b1, 1'b0, 4'd1, 3'b011},
    {1'b1, 1'b1, 1'b1, 4'd3, 3'b011}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] code;
    logic err;
    rst_n = 1'b0; step_go = 1'b0; want_dir = 1'b0; tmo_limit = 8'd4;
    eng_clr = 1'b1; id_v = 0; cmp_v = 0; lat_v = 1; mute_v = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !bit_req && !step_done && !step_err, "R11 in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    eng_clr = 1'b0;
    chk(!busy && !bit_req && !step_done && !step_err, "R11 after reset", busy, 0);

    for (int v = 0; v < 8; v++) begin
      logic vid, vcmp, vdir;
      int   vlat, expn, expreq;
      logic [2:0] vcode;
      {vid, vcmp, vdir} = VEC[v][9:7];
      vlat  = int'(VEC[v][6:3]);
      vcode = VEC[v][2:0];
      run_step(vid, vcmp, vdir, vlat, 0, -1, n, code, err);
      expreq = (vid & vcmp) ? 2 : 3;
      expn   = (vid & vcmp) ? 2*vlat + 3 : 3*vlat + 4;
      chk(code == vcode, "R3 R4 R5 code", code, vcode);
      chk(!err, "R9 no error", err, 0);
      chk(n == expn, "R10 latency", n, expn);
      chk(reqs == expreq, "R1 R2 slot count", reqs, expreq);
      if (expreq == 3)
        chk(wr_seen && wr_val == vcode[2], "R6 write value", wr_val, vcode[2]);
      else
        chk(!wr_seen, "R2 no write slot", wr_seen, 0);
    end

    // R9 boundary: latency 5 with limit 4 still accepted
    run_step(1'b0, 1'b1, 1'b1, 5, 0, -1, n, code, err);
    chk(code == 3'b010 && !err, "R9 edge accepted", code, 3'b010);
    chk(n == 19, "R9 edge latency", n, 19);

    // R9 latency 6: abort in first read phase
    run_step(1'b0, 1'b0, 1'b1, 6, 0, -1, n, code, err);
    chk(code == 3'b011 && err, "R9 abort read", {err, code}, 4'b1011);
    chk(n == 7, "R9 abort read timing", n, 7);
    chk(reqs == 1, "R9 abort no further slot", reqs, 1);

    // R9 write phase silent
    run_step(1'b1, 1'b0, 1'b0, 2, 3, -1, n, code, err);
    chk(code == 3'b011 && err, "R9 abort write", {err, code}, 4'b1011);
    chk(n == 13, "R9 abort write timing", n, 13);

    // R7 start pulse while busy is ignored
    run_step(1'b0, 1'b0, 1'b1, 2, 0, 3, n, code, err);
    chk(code == 3'b100 && n == 10, "R7 timing unchanged", n, 10);
    chk(reqs == 3, "R7 slot count", reqs, 3);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!step_done && !busy && !bit_req, "R7 no second step", step_done, 0);
    end

    // R3 direction sampled at start only
    fork
      run_step(1'b0, 1'b0, 1'b0, 3, 0, -1, n, code, err);
      begin
        repeat (4) @(negedge clk);
        want_dir = 1'b1;
      end
    join
    chk(code == 3'b000, "R3 dir sampled at start", code, 3'b000);

    // R11 reset in the middle of a step
    @(negedge clk);
    eng_clr = 1'b1; lat_v = 3; mute_v = 0;
    @(negedge clk);
    eng_clr = 1'b0; step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && !bit_req && !step_done, "R11 async reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !step_done && !step_err, "R11 idle after reset", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule